// File: doc/BRIEF.md
# Cache Line Maintenance Controller

This block carries out single-line maintenance operations on a small direct-mapped data cache and a small direct-mapped instruction cache. Both caches live inside the block: each line holds a valid bit, a dirty bit, a tag and the line payload. The block receives a 32-bit operation word together with the value of the base register that the word names. It decodes the word and forms the target address. It then runs one of two operations. The first is a data-cache flush that acts only when the address hits, writing a dirty line back first. The second is an instruction-cache flush that drops whichever line the address indexes, whatever its tag holds.

Write-backs leave through a request/acknowledge memory port that carries the line-aligned address and the full line payload. A line-fill port lets the surrounding cache logic install lines. A combinational probe port lets that logic read back the state of any line. Translation, protection, fault reporting and ordinary load/store traffic are handled elsewhere.

Top module: `cache_maint_ctrl`

## Requirements
- R1: A word is a data flush when bits 5:0 equal 0x1B and bits 26:22 are all zero. Bits 21:6 then hold a signed 16-bit offset and bits 31:27 hold the base register index.
- R2: The data flush address is the base value plus the sign-extended offset. The line index is address bits [OFF_W+IDX_W-1:OFF_W], the tag is the bits above those, and OFF_W is log2 of the line size in bytes.
- R3: When a data flush misses (the line is invalid or its tag differs), no memory request is made, the line keeps its valid, dirty and tag state, and done_hit reads 0.
- R4: When a data flush hits a dirty line, the block writes the line back first. It raises mem_req with mem_addr set to {stored tag, index, zero offset} and mem_data set to the line payload. It then invalidates the line and reports done_hit = 1.
- R5: When a data flush hits a clean line, the block invalidates the line without raising mem_req and reports done_hit = 1.
- R6: A word is an instruction flush when bits 5:0 equal 0x3A and bits 16:11 equal 0x0C. It clears the instruction line selected by the index bits of its address, whatever tag that line holds, and leaves every other line alone.
- R7: The instruction flush uses the base value unchanged as its address. The contents of word bits 31:17 and 10:6 have no effect.
- R8: When ICACHE_EN is 0, an instruction flush completes with a done pulse and no memory request. The instruction probe then reads invalid, and instruction fills are dropped.
- R9: busy is high from the cycle after an operation is accepted until done, and an operation is accepted only while busy is low. An op_valid that arrives while busy is high has no effect. done is high for exactly one cycle per operation.
- R10: During a write-back, mem_req, mem_addr and mem_data stay stable until the cycle in which mem_ack is sampled high. The line is invalidated in the next cycle, and done follows one cycle after that.
- R11: A word that decodes as neither operation completes with done, done_hit = 0, no memory request and no change to either cache.
- R12: A fill is written when fill_en is high while busy is low. It sets the chosen line's valid bit, tag, dirty bit and payload. The probe outputs show the selected line's state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation word and base value are valid |
| op_word | input | 32 | Encoded maintenance operation |
| op_base | input | 32 | Value of the base register |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_hit | output | 1 | Data flush found a matching line (valid with done) |
| mem_req | output | 1 | Write-back request |
| mem_addr | output | 32 | Line-aligned write-back address |
| mem_data | output | LINE_BYTES*8 | Write-back line payload |
| mem_ack | input | 1 | Memory accepted the write-back |
| fill_en | input | 1 | Install a line |
| fill_icache | input | 1 | Fill targets the instruction cache (else data) |
| fill_index | input | IDX_W | Line index to fill |
| fill_tag | input | TAG_W | Tag to store |
| fill_dirty | input | 1 | Dirty flag to store (data cache) |
| fill_data | input | LINE_BYTES*8 | Line payload to store |
| probe_icache | input | 1 | Probe the instruction cache (else data) |
| probe_index | input | IDX_W | Line index to probe |
| probe_valid | output | 1 | Probed line valid |
| probe_dirty | output | 1 | Probed line dirty |
| probe_tag | output | TAG_W | Probed line tag |

## Verification
The assertions assume that the memory side raises mem_ack only while mem_req is high, and that the stimulus never pulses ack in an idle cycle. The bench's ack logic responds only to a sampled request and drops ack after one cycle. The checks also assume that fills arrive only while the block is idle, so no fill races a flush on the same line. The bench issues fills strictly between operations. The busy-period rule is then tested on purpose by presenting a second operation mid write-back.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    localparam int ADDR_W = 32;

    localparam logic [5:0] OPC_DFLUSH = 6'h1B;
    localparam logic [5:0] OPC_RTYPE  = 6'h3A;
    localparam logic [5:0] OPX_IFLUSH = 6'h0C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WB,
        ST_INV,
        ST_FIN
    } state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_DFLUSH,
        OP_IFLUSH
    } op_e;

    typedef struct packed {
        op_e               kind;
        logic [ADDR_W-1:0] addr;
    } req_t;

    function automatic logic [ADDR_W-1:0] sext16(input logic [15:0] v);
        return {{(ADDR_W-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/cmc_decode.sv
module cmc_decode
    import cmc_pkg::*;
(
    input  logic [31:0]       word,
    input  logic [ADDR_W-1:0] base,
    output req_t              req
);
    logic is_dflush;
    logic is_iflush;

    assign is_dflush = (word[5:0] == OPC_DFLUSH) && (word[26:22] == 5'd0);
    assign is_iflush = (word[5:0] == OPC_RTYPE) && (word[16:11] == OPX_IFLUSH);

    always_comb begin
        req.kind = OP_NONE;
        req.addr = base;
        if (is_dflush) begin
            req.kind = OP_DFLUSH;
            req.addr = base + sext16(word[21:6]);
        end else if (is_iflush) begin
            req.kind = OP_IFLUSH;
            req.addr = base;
        end
    end
endmodule

// File: rtl/cmc_line_store.sv
module cmc_line_store #(
    parameter int LINES  = 8,
    parameter int TAG_W  = 25,
    parameter int DATA_W = 128,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  pr_idx,
    output logic              pr_valid,
    output logic              pr_dirty,
    output logic [TAG_W-1:0]  pr_tag,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic              w_valid,
    input  logic              w_dirty,
    input  logic [TAG_W-1:0]  w_tag,
    input  logic [DATA_W-1:0] w_data
);
    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (we) begin
            valid_q[w_idx] <= w_valid;
            dirty_q[w_idx] <= w_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tag_q[w_idx]  <= w_tag;
            data_q[w_idx] <= w_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
    assign pr_valid = valid_q[pr_idx];
    assign pr_dirty = dirty_q[pr_idx];
    assign pr_tag   = tag_q[pr_idx];
endmodule

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl
    import cmc_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 8,
    parameter bit ICACHE_EN  = 1'b1,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int IDX_W  = $clog2(NUM_LINES),
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [31:0]       op_word,
    input  logic [31:0]       op_base,
    output logic              busy,
    output logic              done,
    output logic              done_hit,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    output logic [LINE_W-1:0] mem_data,
    input  logic              mem_ack,
    input  logic              fill_en,
    input  logic              fill_icache,
    input  logic [IDX_W-1:0]  fill_index,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              fill_dirty,
    input  logic [LINE_W-1:0] fill_data,
    input  logic              probe_icache,
    input  logic [IDX_W-1:0]  probe_index,
    output logic              probe_valid,
    output logic              probe_dirty,
    output logic [TAG_W-1:0]  probe_tag
);
    state_e st_q;
    req_t   dec_req;
    req_t   cur_q;
    logic   hit_q;

    logic [IDX_W-1:0] cur_idx;
    logic [TAG_W-1:0] cur_tag;

    logic              d_valid, d_dirty;
    logic [TAG_W-1:0]  d_tag;
    logic [LINE_W-1:0] d_data;
    logic              dp_valid, dp_dirty;
    logic [TAG_W-1:0]  dp_tag;
    logic              ip_valid, ip_dirty;
    logic [TAG_W-1:0]  ip_tag;

    logic              fill_ok;
    logic              d_inv, i_inv;
    logic              d_we, i_we;
    logic [IDX_W-1:0]  d_widx, i_widx;
    logic              d_wvalid, d_wdirty;
    logic [TAG_W-1:0]  d_wtag;
    logic [LINE_W-1:0] d_wdata;

    cmc_decode u_dec (
        .word (op_word),
        .base (op_base),
        .req  (dec_req)
    );

    assign cur_idx = cur_q.addr[OFF_W +: IDX_W];
    assign cur_tag = cur_q.addr[ADDR_W-1 -: TAG_W];

    // write-port arbitration: fills only while idle, invalidates in ST_INV
    assign fill_ok = fill_en && (st_q == ST_IDLE);
    assign d_inv   = (st_q == ST_INV) && (cur_q.kind == OP_DFLUSH);
    assign i_inv   = (st_q == ST_INV) && (cur_q.kind == OP_IFLUSH);

    assign d_we     = d_inv || (fill_ok && !fill_icache);
    assign d_widx   = d_inv ? cur_idx : fill_index;
    assign d_wvalid = !d_inv;
    assign d_wdirty = d_inv ? 1'b0 : fill_dirty;
    assign d_wtag   = d_inv ? d_tag  : fill_tag;
    assign d_wdata  = d_inv ? d_data : fill_data;

    assign i_we   = i_inv || (fill_ok && fill_icache);
    assign i_widx = i_inv ? cur_idx : fill_index;

    cmc_line_store #(
        .LINES  (NUM_LINES),
        .TAG_W  (TAG_W),
        .DATA_W (LINE_W)
    ) u_dstore (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (cur_idx),
        .rd_valid (d_valid),
        .rd_dirty (d_dirty),
        .rd_tag   (d_tag),
        .rd_data  (d_data),
        .pr_idx   (probe_index),
        .pr_valid (dp_valid),
        .pr_dirty (dp_dirty),
        .pr_tag   (dp_tag),
        .we       (d_we),
        .w_idx    (d_widx),
        .w_valid  (d_wvalid),
        .w_dirty  (d_wdirty),
        .w_tag    (d_wtag),
        .w_data   (d_wdata)
    );

    generate
        if (ICACHE_EN) begin : g_icache
            logic             i_rvalid, i_rdirty;
            logic [TAG_W-1:0] i_rtag;
            logic [0:0]       i_rdata;

            cmc_line_store #(
                .LINES  (NUM_LINES),
                .TAG_W  (TAG_W),
                .DATA_W (1)
            ) u_istore (
                .clk      (clk),
                .rst      (rst),
                .rd_idx   (cur_idx),
                .rd_valid (i_rvalid),
                .rd_dirty (i_rdirty),
                .rd_tag   (i_rtag),
                .rd_data  (i_rdata),
                .pr_idx   (probe_index),
                .pr_valid (ip_valid),
                .pr_dirty (ip_dirty),
                .pr_tag   (ip_tag),
                .we       (i_we),
                .w_idx    (i_widx),
                .w_valid  (!i_inv),
                .w_dirty  (1'b0),
                .w_tag    (i_inv ? i_rtag : fill_tag),
                .w_data   (fill_data[0])
            );
        end else begin : g_no_icache
            assign ip_valid = 1'b0;
            assign ip_dirty = 1'b0;
            assign ip_tag   = '0;
        end
    endgenerate

    assign probe_valid = probe_icache ? ip_valid : dp_valid;
    assign probe_dirty = probe_icache ? ip_dirty : dp_dirty;
    assign probe_tag   = probe_icache ? ip_tag   : dp_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cur_q    <= '{kind: OP_NONE, addr: '0};
            hit_q    <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (op_valid) begin
                        cur_q <= dec_req;
                        st_q  <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    hit_q <= 1'b0;
                    case (cur_q.kind)
                        OP_DFLUSH: begin
                            if (d_valid && (d_tag == cur_tag)) begin
                                hit_q <= 1'b1;
                                if (d_dirty) begin
                                    mem_addr <= {d_tag, cur_idx, {OFF_W{1'b0}}};
                                    mem_data <= d_data;
                                    st_q     <= ST_WB;
                                end else begin
                                    st_q <= ST_INV;
                                end
                            end else begin
                                st_q <= ST_FIN;
                            end
                        end
                        OP_IFLUSH: st_q <= ICACHE_EN ? ST_INV : ST_FIN;
                        default:   st_q <= ST_FIN;
                    endcase
                end
                ST_WB:   if (mem_ack) st_q <= ST_INV;
                ST_INV:  st_q <= ST_FIN;
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st_q != ST_IDLE);
    assign done     = (st_q == ST_FIN);
    assign done_hit = done && hit_q;
    assign mem_req  = (st_q == ST_WB);
endmodule

// File: rtl/cmc_checker.sv
module cmc_checker #(
    parameter int OFF_W  = 4,
    parameter int LINE_W = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              done_hit,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [31:0]       mem_addr,
    input logic [LINE_W-1:0] mem_data
);
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r10_req_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy && !done);

    a_r10_wb_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_data));

    a_r10_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> !mem_req && !done);

    a_r10_done_after_inv: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_req) |=> done);

    a_r4_wb_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    a_r4_wb_reports_hit: assert property (@(posedge clk) disable iff (rst)
        (done && $past(mem_req, 2)) |-> done_hit);
endmodule

bind cache_maint_ctrl cmc_checker #(
    .OFF_W  (OFF_W),
    .LINE_W (LINE_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .done_hit (done_hit),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_data (mem_data)
);

// File: tb/cache_maint_ctrl_tb.sv
module cache_maint_ctrl_tb;
    localparam int LB = 16;
    localparam int NL = 8;
    localparam int OW = 4;
    localparam int IW = 3;
    localparam int TW = 32 - OW - IW;
    localparam int LW = LB * 8;

    typedef struct {
        bit          hit;
        bit          wb;
        logic [31:0] addr;
        logic [LW-1:0] data;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic op_valid = 0, mem_ack = 0, fill_en = 0, fill_icache = 0, fill_dirty = 0, probe_icache = 0;
    logic [31:0] op_word = '0, op_base = '0;
    logic [IW-1:0] fill_index = '0, probe_index = '0;
    logic [TW-1:0] fill_tag = '0;
    logic [LW-1:0] fill_data = '0;
    logic busy, done, done_hit, mem_req, probe_valid, probe_dirty;
    logic [31:0] mem_addr;
    logic [LW-1:0] mem_data;
    logic [TW-1:0] probe_tag;

    cache_maint_ctrl u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word), .op_base(op_base),
        .busy(busy), .done(done), .done_hit(done_hit), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
        .fill_en(fill_en), .fill_icache(fill_icache), .fill_index(fill_index),
        .fill_tag(fill_tag), .fill_dirty(fill_dirty), .fill_data(fill_data),
        .probe_icache(probe_icache), .probe_index(probe_index),
        .probe_valid(probe_valid), .probe_dirty(probe_dirty), .probe_tag(probe_tag)
    );

    // second instance built without an instruction cache
    logic n_op_valid = 0, n_fill_en = 0;
    logic n_busy, n_done, n_done_hit, n_mem_req, n_pvalid, n_pdirty;
    logic [31:0] n_mem_addr;
    logic [LW-1:0] n_mem_data;
    logic [TW-1:0] n_ptag;

    cache_maint_ctrl #(.ICACHE_EN(1'b0)) u_dut_noic (
        .clk(clk), .rst(rst), .op_valid(n_op_valid), .op_word(op_word), .op_base(op_base),
        .busy(n_busy), .done(n_done), .done_hit(n_done_hit), .mem_req(n_mem_req),
        .mem_addr(n_mem_addr), .mem_data(n_mem_data), .mem_ack(1'b0),
        .fill_en(n_fill_en), .fill_icache(1'b1), .fill_index(fill_index),
        .fill_tag(fill_tag), .fill_dirty(1'b0), .fill_data(fill_data),
        .probe_icache(1'b1), .probe_index(probe_index),
        .probe_valid(n_pvalid), .probe_dirty(n_pdirty), .probe_tag(n_ptag)
    );

    int vectors = 0;
    int errors  = 0;
    int completed = 0;
    int cyc = 0;
    exp_t q[$];

    // bench-side cache model
    bit          m_dval [NL];
    bit          m_ddty [NL];
    logic [TW-1:0] m_dtag [NL];
    logic [LW-1:0] m_ddat [NL];
    bit          m_ival [NL];
    logic [TW-1:0] m_itag [NL];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: acknowledges write-backs and scores completions
    initial begin
        int  wait_cnt = 0;
        bit  wb_seen = 0;
        int  ack_cyc = -1;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wait_cnt < 2) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    wb_seen  = 1;
                    ack_cyc  = cyc;
                    if (q.size() > 0) begin
                        check("R4 wb expected", 1'b1, q[0].wb);
                        check("R4 wb addr", mem_addr, q[0].addr);
                        check("R4 wb data", mem_data, q[0].data);
                    end
                    mem_ack = 1'b1;
                end
            end
            if (done) begin
                if (q.size() == 0) begin
                    check("R9 unexpected done", 1'b1, 1'b0);
                end else begin
                    check("R3/R5 done_hit", done_hit, q[0].hit);
                    check("R3/R5 wb occurred", wb_seen, q[0].wb);
                    if (wb_seen) check("R10 ack to done cycles", cyc - ack_cyc, 2);
                    void'(q.pop_front());
                end
                wb_seen = 0;
                completed++;
            end
        end
    end

    function automatic logic [31:0] w_dflush(input logic [15:0] imm);
        return {5'd3, 5'd0, imm, 6'h1B};
    endfunction

    function automatic logic [31:0] mk(input logic [TW-1:0] t, input int idx);
        return {t, idx[IW-1:0], {OW{1'b0}}};
    endfunction

    task automatic fill(input bit ic, input int idx, input logic [TW-1:0] t, input bit d, input logic [LW-1:0] dat);
        @(negedge clk);
        fill_en = 1; fill_icache = ic; fill_index = idx[IW-1:0]; fill_tag = t; fill_dirty = d; fill_data = dat;
        @(negedge clk);
        fill_en = 0;
        if (ic) begin m_ival[idx] = 1; m_itag[idx] = t; end
        else begin m_dval[idx] = 1; m_ddty[idx] = d; m_dtag[idx] = t; m_ddat[idx] = dat; end
    endtask

    task automatic probe(input string req, input bit ic, input int idx);
        @(negedge clk);
        probe_icache = ic; probe_index = idx[IW-1:0];
        #1;
        if (ic) begin
            check(req, probe_valid, m_ival[idx]);
            if (m_ival[idx]) check(req, probe_tag, m_itag[idx]);
        end else begin
            check(req, probe_valid, m_dval[idx]);
            if (m_dval[idx]) begin
                check(req, probe_dirty, m_ddty[idx]);
                check(req, probe_tag, m_dtag[idx]);
            end
        end
    endtask

    // driver: issue an op, optionally present a second op mid-flight
    task automatic issue(input logic [31:0] w, input logic [31:0] b, input exp_t e,
                         input bit intrude, input logic [31:0] w2, input logic [31:0] b2);
        int target = completed + 1;
        q.push_back(e);
        @(negedge clk);
        op_valid = 1; op_word = w; op_base = b;
        @(negedge clk);
        op_valid = 0;
        if (intrude) begin
            @(negedge clk);
            op_valid = 1; op_word = w2; op_base = b2;
            @(negedge clk);
            op_valid = 0;
        end
        wait (completed >= target);
    endtask

    task automatic dflush(input logic [31:0] b, input logic [15:0] imm, input bit intrude,
                          input logic [31:0] w2, input logic [31:0] b2);
        exp_t e;
        logic [31:0] ea = b + {{16{imm[15]}}, imm};
        int idx = int'(ea[OW +: IW]);
        logic [TW-1:0] t = ea[31 -: TW];
        e.hit  = m_dval[idx] && (m_dtag[idx] == t);
        e.wb   = e.hit && m_ddty[idx];
        e.addr = mk(m_dtag[idx], idx);
        e.data = m_ddat[idx];
        issue(w_dflush(imm), b, e, intrude, w2, b2);
        if (e.hit) begin m_dval[idx] = 0; m_ddty[idx] = 0; end
    endtask

    initial begin
        exp_t e0;
        logic [31:0] iword;
        e0.hit = 0; e0.wb = 0; e0.addr = '0; e0.data = '0;
        for (int i = 0; i < NL; i++) begin
            m_dval[i] = 0; m_ddty[i] = 0; m_dtag[i] = '0; m_ddat[i] = '0;
            m_ival[i] = 0; m_itag[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9 / R12: idle state after reset
        check("R9 reset busy", busy, 1'b0);
        check("R9 reset done", done, 1'b0);
        check("R10 reset mem_req", mem_req, 1'b0);
        probe("R12 reset probe d0", 0, 0);
        probe("R12 reset probe i0", 1, 0);

        fill(0, 2, 25'h155, 1, {4{32'hDEAD_0002}});
        fill(0, 3, 25'h020, 0, {4{32'h0000_0303}});
        fill(0, 5, 25'h077, 1, {4{32'hCAFE_0505}});
        fill(1, 1, 25'h099, 0, '0);
        fill(1, 6, 25'h001, 0, '0);
        probe("R12 fill d2", 0, 2);
        probe("R12 fill i1", 1, 1);

        // R4 / R2: dirty hit with positive offset inside the line
        dflush(mk(25'h155, 2) + 8, 16'd4, 0, '0, '0);
        probe("R4 invalidated d2", 0, 2);
        // R3: same address now misses
        dflush(mk(25'h155, 2), 16'd0, 0, '0, '0);
        // R3: tag mismatch leaves line 5 intact
        dflush(mk(25'h078, 5), 16'd0, 0, '0, '0);
        probe("R3 d5 untouched", 0, 5);
        // R5 / R2: clean hit with negative offset
        dflush(mk(25'h020, 3) + 32'h40, 16'hFFC0, 0, '0, '0);
        probe("R5 invalidated d3", 0, 3);

        // R11 / R1: opcode 0x1B with nonzero bits 26:22 is not a flush
        iword = {5'd3, 5'd1, 16'd0, 6'h1B};
        issue(iword, mk(25'h077, 5), e0, 0, '0, '0);
        probe("R11 d5 untouched", 0, 5);

        // R6 / R7: instruction flush ignores tag and immediate-like fields
        iword = {5'd4, 5'h1F, 5'h15, 6'h0C, 5'h1F, 6'h3A};
        issue(iword, mk(25'hABC, 1) + 3, e0, 0, '0, '0);
        m_ival[1] = 0;
        probe("R6 i1 invalidated", 1, 1);
        probe("R7 i6 kept", 1, 6);
        probe("R7 i3 kept", 1, 3);

        // R9: op presented mid write-back is ignored
        fill(0, 7, 25'h003, 1, {4{32'h7777_0007}});
        dflush(mk(25'h003, 7), 16'd0, 1, w_dflush(16'd0), mk(25'h077, 5));
        probe("R9 d5 kept after intrusion", 0, 5);
        // R2 / R4: negative offset crossing into the previous line
        dflush(mk(25'h077, 6), 16'hFFF0, 0, '0, '0);
        probe("R4 d5 invalidated", 0, 5);

        // R8: no instruction cache configured
        @(negedge clk);
        n_fill_en = 1; fill_index = 3'd2; fill_tag = 25'h5;
        @(negedge clk);
        n_fill_en = 0;
        op_word = {5'd4, 5'd0, 5'd0, 6'h0C, 5'd0, 6'h3A}; op_base = mk(25'h5, 2);
        n_op_valid = 1;
        @(negedge clk);
        n_op_valid = 0;
        begin
            bit got = 0;
            for (int k = 0; k < 6; k++) begin
                if (n_mem_req) check("R8 no mem_req", 1'b1, 1'b0);
                if (n_done) got = 1;
                @(negedge clk);
            end
            check("R8 done pulse", got, 1'b1);
        end
        probe_index = 3'd2;
        #1;
        check("R8 probe invalid", n_pvalid, 1'b0);

        repeat (4) @(negedge clk);
        check("R9 queue drained", q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #50000;
        errors++;
        vectors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule